// File: doc/BRIEF.md
# Reloading Down-Count Timer with APB Register Access

This block is a down-counter that sits behind a zero-wait-state APB slave. Software sets a start value and a reload value, then sets the run bit. From then on the count falls by one at each qualified step. When the count passes from 1 to 0, the block can latch an interrupt. The count stays at zero for one further step and then takes the reload value again, so it runs as a periodic tick source without further attention. The interrupt is a level output. Software acknowledges it by writing a one to the status register.

Steps can come from three sources. The default is every bus clock. A second mode counts only while an external input is high. A third mode counts once per rising edge of that input. The external input passes through a synchroniser and an edge detector before it is used. A read-only bank of identification bytes sits at the top of the 4 KiB window. Every other offset reads as zero and ignores writes.

Top module: `apb_reload_timer`

## Requirements
- R1: After reset, the control, count, reload and status registers all read 0, and irq_o is low.
- R2: The control register at offset 0x000 keeps only bits [3:0]: bit 0 run, bit 1 external level gate, bit 2 external edge stepping, bit 3 interrupt enable. All other bits read as 0.
- R3: The count at 0x004 can be read and written. The reload value at 0x008 can be read and written. A write to 0x008 also loads the same value into the count.
- R4: With run set and no external mode selected, the count decrements once per clock. A step that takes the count from 1 to 0 sets status bit 0 at 0x00C when interrupt enable is set, and irq_o follows that bit.
- R5: After reaching 0, the count holds for one step and then loads the reload value. With reload N ≥ 1, interrupts repeat every N+1 steps.
- R6: Writing 1 to bit 0 of 0x00C clears the status bit and irq_o. Writing 0 leaves it unchanged.
- R7: With interrupt enable clear, expiry never sets the status bit.
- R8: With a reload value of 0, the count stays at 0 after it expires and no further interrupt is raised.
- R9: In level-gate mode, the count decrements once for each clock in which the synchronised external input is high, and not at all while it is low.
- R10: In edge mode, the count decrements once for each rising edge of the external input. If both external modes are selected, a step needs the input high and a rising edge, so a held-high input gives one step.
- R11: Word offsets 0xFD0 to 0xFFC read 0x04, 0x00, 0x00, 0x00, 0x22, 0xB8, 0x1B, 0x00, 0x0D, 0xF0, 0x05, 0xB1 in ascending address order. Writes to them are ignored.
- R12: Offsets outside the registers read 0 and ignore writes. pready_o is always 1 and pslverr_o is always 0.
- R13: With run clear, the count holds its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Bus and count clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| psel_i | input | 1 | APB select |
| penable_i | input | 1 | APB access phase |
| pwrite_i | input | 1 | APB write when high |
| paddr_i | input | 12 | APB byte address |
| pwdata_i | input | 32 | APB write data |
| prdata_o | output | 32 | APB read data, combinational from paddr_i |
| pready_o | output | 1 | Always high |
| pslverr_o | output | 1 | Always low |
| ext_i | input | 1 | Asynchronous external gate or step input |
| irq_o | output | 1 | Level interrupt, equal to the status bit |

## Verification
A count that is wrong by one, or a missing zero-hold step, shows up as an interrupt that rises one clock early or late. The bench counts edges from the enabling write exactly, so the first error is caught within one period of a small reload value. A broken clear or a broken set path shows at irq_o within three clocks of the status write. Faults in the synchroniser or the edge detector show as the wrong count after a known number of external pulses or high cycles. The bench reads that count back as soon as the input has settled.

// File: rtl/timer_pkg.sv
`timescale 1ns/1ps
package timer_pkg;

  typedef struct packed {
    logic irq_en;
    logic ext_clk;
    logic ext_en;
    logic run;
  } ctrl_t;

  localparam int unsigned CTRL_W = $bits(ctrl_t);

  // word addresses (byte offset >> 2)
  localparam logic [9:0] W_CTRL     = 10'h000;
  localparam logic [9:0] W_COUNT    = 10'h001;
  localparam logic [9:0] W_RELOAD   = 10'h002;
  localparam logic [9:0] W_STAT     = 10'h003;
  localparam logic [9:0] W_ID_FIRST = 10'h3F4;
  localparam logic [9:0] W_ID_LAST  = 10'h3FF;

  function automatic logic [7:0] id_byte(input logic [3:0] idx);
    case (idx)
      4'd0:    id_byte = 8'h04;
      4'd4:    id_byte = 8'h22;
      4'd5:    id_byte = 8'hB8;
      4'd6:    id_byte = 8'h1B;
      4'd8:    id_byte = 8'h0D;
      4'd9:    id_byte = 8'hF0;
      4'd10:   id_byte = 8'h05;
      4'd11:   id_byte = 8'hB1;
      default: id_byte = 8'h00;
    endcase
  endfunction

endpackage

// File: rtl/timer_ext_sync.sv
`timescale 1ns/1ps
module timer_ext_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic ext_i,
  output logic lvl_o,
  output logic rise_o
);

  logic [STAGES-1:0] sync_q;
  logic              last_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sync_q <= '0;
      last_q <= 1'b0;
    end else begin
      sync_q <= {sync_q[STAGES-2:0], ext_i};
      last_q <= sync_q[STAGES-1];
    end
  end

  assign lvl_o  = sync_q[STAGES-1];
  assign rise_o = sync_q[STAGES-1] & ~last_q;

endmodule

// File: rtl/timer_count_core.sv
`timescale 1ns/1ps
module timer_count_core #(
  parameter int unsigned CNT_W = 32
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             tick_i,
  input  logic             load_i,
  input  logic [CNT_W-1:0] load_val_i,
  input  logic [CNT_W-1:0] reload_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic             expire_o
);

  logic [CNT_W-1:0] cnt_q;

  // bus write wins over a step in the same cycle
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
    end else if (load_i) begin
      cnt_q <= load_val_i;
    end else if (tick_i) begin
      if (cnt_q == '0) cnt_q <= reload_i;
      else             cnt_q <= cnt_q - CNT_W'(1);
    end
  end

  assign cnt_o    = cnt_q;
  assign expire_o = tick_i & ~load_i & (cnt_q == CNT_W'(1));

endmodule

// File: rtl/timer_apb_regs.sv
`timescale 1ns/1ps
module timer_apb_regs
  import timer_pkg::*;
#(
  parameter int unsigned ADDR_W = 12,
  parameter int unsigned DATA_W = 32,
  parameter int unsigned CNT_W  = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              psel_i,
  input  logic              penable_i,
  input  logic              pwrite_i,
  input  logic [ADDR_W-1:0] paddr_i,
  input  logic [DATA_W-1:0] pwdata_i,
  output logic [DATA_W-1:0] prdata_o,
  input  logic [CNT_W-1:0]  cnt_i,
  input  logic              expire_i,
  output ctrl_t             ctrl_o,
  output logic [CNT_W-1:0]  reload_o,
  output logic              load_o,
  output logic [CNT_W-1:0]  load_val_o,
  output logic              irq_o
);

  localparam int unsigned WA = ADDR_W - 2;
  localparam logic [WA-1:0] A_CTRL   = WA'(W_CTRL);
  localparam logic [WA-1:0] A_COUNT  = WA'(W_COUNT);
  localparam logic [WA-1:0] A_RELOAD = WA'(W_RELOAD);
  localparam logic [WA-1:0] A_STAT   = WA'(W_STAT);
  localparam logic [WA-1:0] A_ID_LO  = WA'(W_ID_FIRST);
  localparam logic [WA-1:0] A_ID_HI  = WA'(W_ID_LAST);

  logic [WA-1:0]    word;
  logic             wr_en;
  ctrl_t            ctrl_q;
  logic [CNT_W-1:0] reload_q;
  logic             stat_q;
  logic [1:0]       unused_lsb;

  assign word       = paddr_i[ADDR_W-1:2];
  assign unused_lsb = paddr_i[1:0];
  assign wr_en      = psel_i & penable_i & pwrite_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ctrl_q   <= '0;
      reload_q <= '0;
    end else if (wr_en) begin
      if (word == A_CTRL)   ctrl_q   <= ctrl_t'(pwdata_i[CTRL_W-1:0]);
      if (word == A_RELOAD) reload_q <= pwdata_i[CNT_W-1:0];
    end
  end

  // expiry set beats a same-cycle clear
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      stat_q <= 1'b0;
    end else if (expire_i && ctrl_q.irq_en) begin
      stat_q <= 1'b1;
    end else if (wr_en && word == A_STAT && pwdata_i[0]) begin
      stat_q <= 1'b0;
    end
  end

  always_comb begin
    prdata_o = '0;
    if (word == A_CTRL)        prdata_o = DATA_W'(ctrl_q);
    else if (word == A_COUNT)  prdata_o = DATA_W'(cnt_i);
    else if (word == A_RELOAD) prdata_o = DATA_W'(reload_q);
    else if (word == A_STAT)   prdata_o = DATA_W'(stat_q);
    else if (word >= A_ID_LO && word <= A_ID_HI)
      prdata_o = DATA_W'(id_byte(4'(word - A_ID_LO)));
  end

  assign ctrl_o     = ctrl_q;
  assign reload_o   = reload_q;
  assign load_o     = wr_en & ((word == A_COUNT) | (word == A_RELOAD));
  assign load_val_o = pwdata_i[CNT_W-1:0];
  assign irq_o      = stat_q;

endmodule

// File: rtl/apb_reload_timer.sv
`timescale 1ns/1ps
module apb_reload_timer
  import timer_pkg::*;
#(
  parameter int unsigned ADDR_W      = 12,
  parameter int unsigned DATA_W      = 32,
  parameter int unsigned CNT_W       = 32,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              psel_i,
  input  logic              penable_i,
  input  logic              pwrite_i,
  input  logic [ADDR_W-1:0] paddr_i,
  input  logic [DATA_W-1:0] pwdata_i,
  output logic [DATA_W-1:0] prdata_o,
  output logic              pready_o,
  output logic              pslverr_o,
  input  logic              ext_i,
  output logic              irq_o
);

  ctrl_t            ctrl;
  logic [CNT_W-1:0] reload;
  logic [CNT_W-1:0] cnt;
  logic [CNT_W-1:0] load_val;
  logic             load;
  logic             expire;
  logic             ext_lvl;
  logic             ext_rise;
  logic             tick;
  logic             run_en;
  logic             irq_en;

  timer_apb_regs #(
    .ADDR_W (ADDR_W),
    .DATA_W (DATA_W),
    .CNT_W  (CNT_W)
  ) u_regs (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .psel_i     (psel_i),
    .penable_i  (penable_i),
    .pwrite_i   (pwrite_i),
    .paddr_i    (paddr_i),
    .pwdata_i   (pwdata_i),
    .prdata_o   (prdata_o),
    .cnt_i      (cnt),
    .expire_i   (expire),
    .ctrl_o     (ctrl),
    .reload_o   (reload),
    .load_o     (load),
    .load_val_o (load_val),
    .irq_o      (irq_o)
  );

  timer_ext_sync #(
    .STAGES (SYNC_STAGES)
  ) u_sync (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .ext_i  (ext_i),
    .lvl_o  (ext_lvl),
    .rise_o (ext_rise)
  );

  // both ext modes set: need level and edge together
  assign tick = ctrl.run
              & (~ctrl.ext_en  | ext_lvl)
              & (~ctrl.ext_clk | ext_rise);

  timer_count_core #(
    .CNT_W (CNT_W)
  ) u_core (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .tick_i     (tick),
    .load_i     (load),
    .load_val_i (load_val),
    .reload_i   (reload),
    .cnt_o      (cnt),
    .expire_o   (expire)
  );

  assign run_en    = ctrl.run;
  assign irq_en    = ctrl.irq_en;
  assign pready_o  = 1'b1;
  assign pslverr_o = 1'b0;

endmodule

// File: rtl/timer_checker.sv
`timescale 1ns/1ps
module timer_checker #(
  parameter int unsigned W = 32
) (
  input logic         clk_i,
  input logic         rst_ni,
  input logic         irq_o,
  input logic         pready_o,
  input logic         pslverr_o,
  input logic [W-1:0] cnt,
  input logic [W-1:0] reload,
  input logic         tick,
  input logic         load,
  input logic         run_en,
  input logic         irq_en
);

  p_irq_rise_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(irq_o) |-> ($past(cnt) == W'(1)) && (cnt == '0));

  p_step_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tick && !load && cnt != '0) |=> cnt == $past(cnt) - W'(1));

  p_reload_after_zero_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tick && !load && cnt == '0) |=> cnt == $past(reload));

  p_no_irq_when_off_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!irq_en && !irq_o) |=> !irq_o);

  p_zero_reload_stays_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cnt == '0 && reload == '0 && !load) |=> cnt == '0);

  p_bus_ok_r12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pready_o && !pslverr_o);

  p_hold_stopped_r13: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!run_en && !load) |=> $stable(cnt));

endmodule

bind apb_reload_timer timer_checker #(.W(CNT_W)) u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .irq_o     (irq_o),
  .pready_o  (pready_o),
  .pslverr_o (pslverr_o),
  .cnt       (cnt),
  .reload    (reload),
  .tick      (tick),
  .load      (load),
  .run_en    (run_en),
  .irq_en    (irq_en)
);

// File: tb/sim_apb_reload_timer.sv
`timescale 1ns/1ps
module sim_apb_reload_timer;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        psel = 1'b0, penable = 1'b0, pwrite = 1'b0;
  logic [11:0] paddr = '0;
  logic [31:0] pwdata = '0;
  logic [31:0] prdata;
  logic        pready, pslverr;
  logic        ext = 1'b0;
  logic        irq;

  int total = 0;
  int bad   = 0;

  localparam logic [7:0] ID_TBL [12] = '{8'h04, 8'h00, 8'h00, 8'h00,
                                         8'h22, 8'hB8, 8'h1B, 8'h00,
                                         8'h0D, 8'hF0, 8'h05, 8'hB1};

  always #10 clk = ~clk;

  apb_reload_timer u0 (
    .clk_i     (clk),
    .rst_ni    (rst_n),
    .psel_i    (psel),
    .penable_i (penable),
    .pwrite_i  (pwrite),
    .paddr_i   (paddr),
    .pwdata_i  (pwdata),
    .prdata_o  (prdata),
    .pready_o  (pready),
    .pslverr_o (pslverr),
    .ext_i     (ext),
    .irq_o     (irq)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(input logic [11:0] a, input logic [31:0] d);
    @(negedge clk);
    psel = 1'b1; penable = 1'b0; pwrite = 1'b1; paddr = a; pwdata = d;
    @(negedge clk);
    penable = 1'b1;
    @(negedge clk);
    psel = 1'b0; penable = 1'b0; pwrite = 1'b0;
  endtask

  task automatic rd(input logic [11:0] a, output logic [31:0] d);
    @(negedge clk);
    psel = 1'b1; penable = 1'b0; pwrite = 1'b0; paddr = a;
    @(negedge clk);
    penable = 1'b1;
    #1 d = prdata;
    @(negedge clk);
    psel = 1'b0; penable = 1'b0;
  endtask

  task automatic pulse(input int hi, input int lo);
    @(negedge clk); ext = 1'b1;
    cyc(hi);
    ext = 1'b0;
    cyc(lo);
  endtask

  initial begin
    #(20 * 150000);
    bad++;
    $display("FAIL watchdog actual=running expected=done");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [31:0] r;
    int k;
    cyc(3);
    rst_n = 1'b1;

    // R1 reset state
    rd(12'h000, r); chk("R1 ctrl", r, 0);
    rd(12'h004, r); chk("R1 count", r, 0);
    rd(12'h008, r); chk("R1 reload", r, 0);
    rd(12'h00C, r); chk("R1 status", r, 0);
    chk("R1 irq", {31'd0, irq}, 0);
    chk("R12 pready", {31'd0, pready}, 1);
    chk("R12 pslverr", {31'd0, pslverr}, 0);

    // R2 control width
    wr(12'h000, 32'hFFFF_FFF0); rd(12'h000, r); chk("R2 upper dropped", r, 0);
    wr(12'h000, 32'hFFFF_FFFE); rd(12'h000, r); chk("R2 low bits kept", r, 32'hE);
    wr(12'h000, 32'h0);

    // R3 / R13 count and reload access while stopped
    wr(12'h004, 32'h1234_5678); rd(12'h004, r); chk("R3 count rw", r, 32'h1234_5678);
    wr(12'h008, 32'h0000_ABCD); rd(12'h004, r); chk("R3 reload loads count", r, 32'hABCD);
    rd(12'h008, r); chk("R3 reload rw", r, 32'hABCD);
    cyc(5);
    rd(12'h004, r); chk("R13 stopped holds", r, 32'hABCD);

    // R12 unmapped offsets
    foreach (ID_TBL[i]) begin end
    for (int i = 0; i < 4; i++) begin
      logic [11:0] a;
      a = (i == 0) ? 12'h010 : (i == 1) ? 12'h014 : (i == 2) ? 12'h800 : 12'hFCC;
      wr(a, 32'hFFFF_FFFF);
      rd(a, r); chk("R12 unmapped reads 0", r, 0);
    end
    rd(12'h008, r); chk("R12 writes ignored reload", r, 32'hABCD);
    rd(12'h000, r); chk("R12 writes ignored ctrl", r, 0);

    // R11 identification bank
    for (int i = 0; i < 12; i++) begin
      rd(12'hFD0 + 12'(4 * i), r);
      chk("R11 id byte", r, {24'd0, ID_TBL[i]});
    end
    wr(12'hFD0, 32'hFF); rd(12'hFD0, r); chk("R11 id read-only", r, 32'h04);

    // R4 / R5 / R6 period sweep
    for (int n = 3; n <= 8; n++) begin
      wr(12'h000, 32'h0);
      wr(12'h008, 32'(n));
      wr(12'h00C, 32'h1);
      wr(12'h000, 32'h9);
      k = 0;
      while (!irq && k < 100) begin @(negedge clk); k++; end
      chk("R4 first expiry cycles", 32'(k), 32'(n));
      wr(12'h00C, 32'h1);
      chk("R6 w1c clears", {31'd0, irq}, 0);
      k = 0;
      while (!irq && k < 100) begin @(negedge clk); k++; end
      chk("R5 period reload+1", 32'(k), 32'(n - 2));
      wr(12'h00C, 32'h0);
      chk("R6 write 0 keeps", {31'd0, irq}, 1);
    end
    wr(12'h000, 32'h0);
    wr(12'h00C, 32'h1);

    // R7 interrupt enable off
    wr(12'h008, 32'd4);
    wr(12'h000, 32'h1);
    cyc(30);
    chk("R7 no irq", {31'd0, irq}, 0);
    rd(12'h00C, r); chk("R7 status clear", r, 0);
    wr(12'h000, 32'h0);

    // R8 zero reload
    wr(12'h008, 32'd0);
    wr(12'h004, 32'd3);
    wr(12'h000, 32'h9);
    cyc(5);
    chk("R8 single expiry", {31'd0, irq}, 1);
    wr(12'h00C, 32'h1);
    cyc(30);
    chk("R8 no further irq", {31'd0, irq}, 0);
    wr(12'h000, 32'h0);
    rd(12'h004, r); chk("R8 count stays 0", r, 0);

    // R9 external level gate
    wr(12'h004, 32'd1000);
    wr(12'h000, 32'h3);
    cyc(10);
    rd(12'h004, r); chk("R9 low input holds", r, 32'd1000);
    pulse(7, 6);
    rd(12'h004, r); chk("R9 seven high cycles", r, 32'd993);
    pulse(13, 6);
    rd(12'h004, r); chk("R9 thirteen high cycles", r, 32'd980);
    wr(12'h000, 32'h0);

    // R10 external edge stepping
    wr(12'h008, 32'd5);
    wr(12'h00C, 32'h1);
    wr(12'h000, 32'hD);
    cyc(10);
    rd(12'h004, r); chk("R10 no edges no step", r, 32'd5);
    for (int p = 1; p <= 4; p++) begin
      pulse(3, 4);
      rd(12'h004, r); chk("R10 one step per edge", r, 32'(5 - p));
    end
    chk("R10 no irq before last edge", {31'd0, irq}, 0);
    pulse(3, 4);
    chk("R10 irq on fifth edge", {31'd0, irq}, 1);
    wr(12'h000, 32'h0);
    wr(12'h00C, 32'h1);

    // R10 both modes: held-high input gives a single step
    wr(12'h004, 32'd10);
    wr(12'h000, 32'h7);
    pulse(20, 5);
    rd(12'h004, r); chk("R10 both modes one step", r, 32'd9);
    wr(12'h000, 32'h0);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule